// File: doc/BRIEF.md
# Host-to-SPI Flash Erase Command Bridge

This block lets a host erase one sector or block of an attached serial flash by working through a short handshake with a local CPU. The host first writes the erase command byte to a command port. This raises a command flag and a busy flag, and it interrupts the CPU. The CPU answers by arming a capture mode and clearing those two flags. The host can poll for that state. The host then writes to the address it wants erased. That write is not passed on to the memory path. The block keeps the low address bits as the flash address and keeps the data byte.

A second command write interrupts the CPU again. The CPU clears the command flag and starts the serial transfer. The serial transfer sends the command byte, then the captured address with its lowest byte first. Each byte goes out most significant bit first, in SPI mode 0, with select held low for the whole frame. A one-cycle end pulse and a sticky done flag mark the end of the transfer. When the capture mode is not armed, host memory writes pass through unchanged.

Top module: `flash_erase_bridge`

## Requirements
- R1: After reset the status word is 0, `cpu_irq` is low, `fwd_wr` is low, `spi_cs_n` is high and `spi_sck` is low.
- R2: The status word has these bits: bit 0 is the command flag, bit 1 is busy, bit 2 is capture-armed and bit 3 is transfer-done. A `host_cmd_wr` accepted while busy is 0 sets bit 0 and bit 1 in the next cycle. It also latches the byte into `cap_cmd`, and `cpu_irq` follows bit 0.
- R3: A `host_cmd_wr` while busy is 1 is ignored: the status word and `cap_cmd` keep their values.
- R4: A CPU write with `cpu_sel`=0 clears each of status bits 0, 1 and 3 whose data bit is 1, and leaves the other bits alone. Data bit 2 = 1 sets capture-armed.
- R5: While capture-armed is 0, a `host_mem_wr` shows up in the same cycle on `fwd_wr`/`fwd_addr`/`fwd_data` unchanged, and the capture registers do not change.
- R6: While capture-armed is 1, a `host_mem_wr` is not forwarded. Its low 24 address bits go into `cap_addr` and its byte goes into `cap_wdata`, and capture-armed drops to 0 in the next cycle.
- R7: A CPU write with `cpu_sel`=1 and data bit 0 = 1 starts a frame. The frame is `cap_cmd`, then the `cap_addr` bytes from the lowest to the highest. Each byte goes out MSB first. `spi_sck` idles low and `spi_mosi` stays stable while `spi_sck` is high.
- R8: `spi_cs_n` falls one half period before the first rising edge of `spi_sck`. It rises one half period after the last falling edge. A frame has exactly 8 × (1 + address bytes) rising edges.
- R9: At the end of a frame, `tx_end` is high for exactly one cycle. The same event sets status bit 3 and clears busy.
- R10: A start request while a frame is still in progress is ignored: no extra bits go out and no second end pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cmd_wr | input | 1 | Host write strobe to the command port |
| host_cmd_data | input | 8 | Command byte |
| host_mem_wr | input | 1 | Host write strobe to the memory window |
| host_mem_addr | input | HADDR_W (32) | Host write address |
| host_mem_data | input | 8 | Host write data |
| fwd_wr | output | 1 | Forwarded memory write strobe |
| fwd_addr | output | HADDR_W (32) | Forwarded address |
| fwd_data | output | 8 | Forwarded data |
| host_status | output | 4 | Status word the host can poll |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_sel | input | 1 | 0 selects the status word, 1 selects the start control |
| cpu_wdata | input | 8 | CPU write data |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cap_cmd | output | 8 | Latched command byte |
| cap_addr | output | 24 | Captured flash address |
| cap_wdata | output | 8 | Captured write byte |
| spi_cs_n | output | 1 | Serial select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| tx_end | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with a half period of two clocks, three address bytes and a 32-bit host address. With a half period longer than one clock, the lead and trail windows of select can be told apart from a single-cycle slip when measured in time. The 32-bit host address has nonzero upper bits, which shows that they are dropped on capture. The example address then yields the stream 0x52, 0x76, 0x4A, 0x06, and the bench compares it bit for bit.

// File: rtl/erb_pkg.sv
package erb_pkg;
   localparam int ST_W     = 4;
   localparam int ST_CMD   = 0;
   localparam int ST_BUSY  = 1;
   localparam int ST_ARMED = 2;
   localparam int ST_DONE  = 3;

   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_LEAD  = 2'd1,
      SH_SHIFT = 2'd2,
      SH_TRAIL = 2'd3
   } sh_state_e;
endpackage

// File: rtl/erb_status.sv
module erb_status
   import erb_pkg::*;
#(
   parameter int CMD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_cmd_wr,
   input  logic [CMD_W-1:0] host_cmd_data,
   input  logic             cpu_st_wr,
   input  logic [ST_W-1:0]  cpu_st_data,
   input  logic             capture_hit,
   input  logic             xfer_done,
   output logic [ST_W-1:0]  status,
   output logic [CMD_W-1:0] cmd_q
);
   logic cmd_flag, busy, armed, done;
   logic accept;
   logic [ST_W-1:0] w1c;

   assign accept = host_cmd_wr & ~busy;
   assign w1c    = cpu_st_wr ? cpu_st_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_flag <= 1'b0;
         busy     <= 1'b0;
         armed    <= 1'b0;
         done     <= 1'b0;
         cmd_q    <= '0;
      end else begin
         if (accept) begin
            cmd_flag <= 1'b1;
            busy     <= 1'b1;
            cmd_q    <= host_cmd_data;
         end else begin
            if (w1c[ST_CMD]) cmd_flag <= 1'b0;
            if (w1c[ST_BUSY] || xfer_done) busy <= 1'b0;
         end
         if (w1c[ST_ARMED])    armed <= 1'b1;
         else if (capture_hit) armed <= 1'b0;
         if (xfer_done)        done <= 1'b1;
         else if (w1c[ST_DONE]) done <= 1'b0;
      end
   end

   always_comb begin
      status           = '0;
      status[ST_CMD]   = cmd_flag;
      status[ST_BUSY]  = busy;
      status[ST_ARMED] = armed;
      status[ST_DONE]  = done;
   end

   a_r2_accept_sets_flags : assert property (@(posedge clk) disable iff (!rst_n)
      (host_cmd_wr && !busy) |=> (cmd_flag && busy));
   a_r3_busy_cmd_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (host_cmd_wr && busy) |=> $stable(cmd_q));
   a_r9_done_sets_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> (done && !busy));
endmodule

// File: rtl/erb_capture.sv
module erb_capture #(
   parameter int HADDR_W = 32,
   parameter int FADDR_W = 24,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_mem_wr,
   input  logic [HADDR_W-1:0] host_mem_addr,
   input  logic [DATA_W-1:0]  host_mem_data,
   input  logic               armed,
   output logic               fwd_wr,
   output logic [HADDR_W-1:0] fwd_addr,
   output logic [DATA_W-1:0]  fwd_data,
   output logic               capture_hit,
   output logic [FADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0]  cap_wdata
);
   logic [FADDR_W-1:0] addr_low;

   initial begin : p_params
      assert (HADDR_W >= FADDR_W) else $error("host address narrower than flash address");
      assert (FADDR_W % 8 == 0)   else $error("flash address must be whole bytes");
   end

   generate
      if (HADDR_W == FADDR_W) begin : g_same
         assign addr_low = host_mem_addr;
      end else begin : g_trunc
         assign addr_low = host_mem_addr[FADDR_W-1:0];
      end
   endgenerate

   assign capture_hit = host_mem_wr & armed;
   assign fwd_wr      = host_mem_wr & ~armed;
   assign fwd_addr    = host_mem_addr;
   assign fwd_data    = host_mem_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_addr  <= '0;
         cap_wdata <= '0;
      end else if (capture_hit) begin
         cap_addr  <= addr_low;
         cap_wdata <= host_mem_data;
      end
   end

   a_r6_no_forward_when_armed : assert property (@(posedge clk) disable iff (!rst_n)
      (armed && host_mem_wr) |-> !fwd_wr);
   a_r5_hold_when_unarmed : assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> ($stable(cap_addr) && $stable(cap_wdata)));
endmodule

// File: rtl/erb_spi_tx.sv
module erb_spi_tx
   import erb_pkg::*;
#(
   parameter int NBYTES  = 4,
   parameter int SCK_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NBYTES*8-1:0] frame,
   output logic              cs_n,
   output logic              sck,
   output logic              mosi,
   output logic              done
);
   localparam int NBITS = NBYTES * 8;
   localparam int BCW   = $clog2(NBITS);
   localparam int DCW   = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;

   sh_state_e        state;
   logic [NBITS-1:0] shreg;
   logic [BCW-1:0]   bitcnt;
   logic             tick;

   initial begin : p_params
      assert (SCK_DIV >= 1) else $error("SCK_DIV must be at least 1");
      assert (NBYTES >= 2)  else $error("frame needs command and address");
   end

   generate
      if (SCK_DIV == 1) begin : g_fast
         assign tick = 1'b1;
      end else begin : g_div
         logic [DCW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || state == SH_IDLE) cnt <= '0;
            else if (cnt == DCW'(SCK_DIV - 1)) cnt <= '0;
            else cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == DCW'(SCK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SH_IDLE;
         shreg  <= '0;
         bitcnt <= '0;
         sck    <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            SH_IDLE: if (start) begin
               state  <= SH_LEAD;
               shreg  <= frame;
               bitcnt <= '0;
            end
            SH_LEAD: if (tick) begin
               state <= SH_SHIFT;
               sck   <= 1'b1;
            end
            SH_SHIFT: if (tick) begin
               if (!sck) begin
                  sck <= 1'b1;
               end else begin
                  sck <= 1'b0;
                  if (bitcnt == BCW'(NBITS - 1)) begin
                     state <= SH_TRAIL;
                  end else begin
                     shreg  <= {shreg[NBITS-2:0], 1'b0};
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
            end
            SH_TRAIL: if (tick) begin
               state <= SH_IDLE;
               done  <= 1'b1;
            end
            default: state <= SH_IDLE;
         endcase
      end
   end

   assign cs_n = (state == SH_IDLE);
   assign mosi = shreg[NBITS-1];

   a_r8_sck_low_when_deselected : assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);
   a_r7_mosi_stable_while_high : assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));
   a_r9_end_single_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_start_ignored_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_SHIFT && start) |=> (state != SH_LEAD));
endmodule

// File: rtl/flash_erase_bridge.sv
module flash_erase_bridge
   import erb_pkg::*;
#(
   parameter int HADDR_W    = 32,
   parameter int ADDR_BYTES = 3,
   parameter int SCK_DIV    = 2,
   localparam int FADDR_W   = ADDR_BYTES * 8,
   localparam int NBYTES    = ADDR_BYTES + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_cmd_wr,
   input  logic [7:0]         host_cmd_data,
   input  logic               host_mem_wr,
   input  logic [HADDR_W-1:0] host_mem_addr,
   input  logic [7:0]         host_mem_data,
   output logic               fwd_wr,
   output logic [HADDR_W-1:0] fwd_addr,
   output logic [7:0]         fwd_data,
   output logic [3:0]         host_status,
   input  logic               cpu_wr,
   input  logic               cpu_sel,
   input  logic [7:0]         cpu_wdata,
   output logic               cpu_irq,
   output logic [7:0]         cap_cmd,
   output logic [FADDR_W-1:0] cap_addr,
   output logic [7:0]         cap_wdata,
   output logic               spi_cs_n,
   output logic               spi_sck,
   output logic               spi_mosi,
   output logic               tx_end
);
   logic [ST_W-1:0]     status;
   logic                capture_hit;
   logic                start;
   logic [NBYTES*8-1:0] frame;

   assign start = cpu_wr & cpu_sel & cpu_wdata[0];

   erb_status #(.CMD_W(8)) u_status (
      .clk(clk), .rst_n(rst_n),
      .host_cmd_wr(host_cmd_wr), .host_cmd_data(host_cmd_data),
      .cpu_st_wr(cpu_wr & ~cpu_sel), .cpu_st_data(cpu_wdata[ST_W-1:0]),
      .capture_hit(capture_hit), .xfer_done(tx_end),
      .status(status), .cmd_q(cap_cmd)
   );

   erb_capture #(.HADDR_W(HADDR_W), .FADDR_W(FADDR_W), .DATA_W(8)) u_capture (
      .clk(clk), .rst_n(rst_n),
      .host_mem_wr(host_mem_wr), .host_mem_addr(host_mem_addr),
      .host_mem_data(host_mem_data), .armed(status[ST_ARMED]),
      .fwd_wr(fwd_wr), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
      .capture_hit(capture_hit), .cap_addr(cap_addr), .cap_wdata(cap_wdata)
   );

   // Command byte leads; address follows lowest byte first.
   assign frame[NBYTES*8-1 -: 8] = cap_cmd;
   generate
      for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_frame
         assign frame[(ADDR_BYTES-1-i)*8 +: 8] = cap_addr[i*8 +: 8];
      end
   endgenerate

   erb_spi_tx #(.NBYTES(NBYTES), .SCK_DIV(SCK_DIV)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .frame(frame),
      .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi), .done(tx_end)
   );

   assign host_status = status;
   assign cpu_irq     = status[ST_CMD];

   a_r2_irq_tracks_flag : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_irq) |-> $past(host_cmd_wr));
endmodule

// File: tb/tb_flash_erase_bridge.sv
module tb_flash_erase_bridge;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        host_cmd_wr = 0;
   logic [7:0]  host_cmd_data = 0;
   logic        host_mem_wr = 0;
   logic [31:0] host_mem_addr = 0;
   logic [7:0]  host_mem_data = 0;
   logic        fwd_wr;
   logic [31:0] fwd_addr;
   logic [7:0]  fwd_data;
   logic [3:0]  host_status;
   logic        cpu_wr = 0, cpu_sel = 0;
   logic [7:0]  cpu_wdata = 0;
   logic        cpu_irq;
   logic [7:0]  cap_cmd, cap_wdata;
   logic [23:0] cap_addr;
   logic        spi_cs_n, spi_sck, spi_mosi, tx_end;

   int n_chk = 0, n_fail = 0;
   int nrise = 0, ntx = 0, nwide = 0;
   logic [31:0] rx = 0;
   time t_csf, t_first, t_lastf, t_csr;
   logic prev_tx = 0;

   always #4 clk = ~clk;

   flash_erase_bridge #(.HADDR_W(32), .ADDR_BYTES(3), .SCK_DIV(2)) dut (.*);

   always @(posedge spi_sck) if (!spi_cs_n) begin
      if (nrise == 0) t_first = $time;
      rx = {rx[30:0], spi_mosi};
      nrise++;
   end
   always @(negedge spi_sck) t_lastf = $time;
   always @(negedge spi_cs_n) t_csf = $time;
   always @(posedge spi_cs_n) t_csr = $time;
   always @(posedge clk) begin
      if (tx_end) ntx++;
      if (tx_end && prev_tx) nwide++;
      prev_tx = tx_end;
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(); @(negedge clk); endtask

   task automatic cpu_write(logic sel, logic [7:0] d);
      cpu_wr = 1; cpu_sel = sel; cpu_wdata = d;
      cyc(); cpu_wr = 0;
   endtask

   task automatic host_cmd(logic [7:0] d);
      host_cmd_wr = 1; host_cmd_data = d;
      cyc(); host_cmd_wr = 0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 2000; i++) begin
         if (host_status[3]) break;
         cyc();
      end
      repeat (3) cyc();
   endtask

   task automatic t_reset();
      check("R1 status", host_status, 4'h0);
      check("R1 irq", cpu_irq, 1'b0);
      check("R1 fwd", fwd_wr, 1'b0);
      check("R1 cs_n", spi_cs_n, 1'b1);
      check("R1 sck", spi_sck, 1'b0);
   endtask

   task automatic t_forward();
      host_mem_wr = 1; host_mem_addr = 32'h1234_5678; host_mem_data = 8'hA5;
      #1;
      check("R5 fwd_wr", fwd_wr, 1'b1);
      check("R5 fwd_addr", fwd_addr, 32'h1234_5678);
      check("R5 fwd_data", fwd_data, 8'hA5);
      cyc(); host_mem_wr = 0;
      check("R5 no capture", cap_addr, 24'h0);
   endtask

   task automatic t_step1();
      host_cmd(8'h52);
      check("R2 status", host_status, 4'b0011);
      check("R2 irq", cpu_irq, 1'b1);
      check("R2 cmd", cap_cmd, 8'h52);
      host_cmd(8'h9F);
      check("R3 status", host_status, 4'b0011);
      check("R3 cmd", cap_cmd, 8'h52);
      cpu_write(0, 8'h07);
      check("R4 arm+clear", host_status, 4'b0100);
      check("R4 irq low", cpu_irq, 1'b0);
   endtask

   task automatic t_step2();
      host_mem_wr = 1; host_mem_addr = 32'h0A06_4A76; host_mem_data = 8'h3C;
      #1;
      check("R6 not forwarded", fwd_wr, 1'b0);
      cyc(); host_mem_wr = 0;
      check("R6 addr", cap_addr, 24'h064A76);
      check("R6 data", cap_wdata, 8'h3C);
      check("R6 disarm", host_status, 4'b0000);
   endtask

   task automatic t_step3();
      host_cmd(8'h52);
      check("R2 second cmd", host_status, 4'b0011);
      cpu_write(0, 8'h01);
      check("R4 only cmd cleared", host_status, 4'b0010);
   endtask

   task automatic t_transfer(bit restart);
      nrise = 0; ntx = 0; nwide = 0; rx = 0;
      cpu_write(1, 8'h01);
      if (restart) begin
         repeat (12) cyc();
         cpu_write(1, 8'h01);
      end
      wait_end();
      check(restart ? "R10 stream" : "R7 stream", rx, 32'h5276_4A06);
      check(restart ? "R10 edges" : "R8 edges", nrise, 32);
      check("R8 lead", 32'(t_first - t_csf), 16);
      check("R8 trail", 32'(t_csr - t_lastf), 16);
      check(restart ? "R10 one end" : "R9 one end", ntx, 1);
      check("R9 width", nwide, 0);
      check("R9 status", host_status, 4'b1000);
      check("R7 sck idle", spi_sck, 1'b0);
   endtask

   initial begin
      repeat (4) cyc();
      rst_n = 1;
      cyc();
      t_reset();
      t_forward();
      t_step1();
      t_step2();
      t_step3();
      t_transfer(0);
      cpu_write(0, 8'h08);
      check("R4 clear done", host_status, 4'b0000);
      t_transfer(1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule